// File: doc/BRIEF.md
# Serial ADC Slave Port

This block is the digital front end of an 8-bit multichannel converter. Each access is one full-duplex frame of eight serial clocks. During the frame the host shifts in a 4-bit channel number. At the same time the block shifts out the result of the previous conversion. When the frame ends, the block latches the channel number, pulses a start request to the conversion sequencer, and ignores the serial clock until that conversion is finished.

All serial inputs are brought into the block clock domain through two-flop synchronisers, and their edges are detected in that domain. The block clock must therefore run several times faster than the serial clock. The serial clock may stop for any length of time between edges.

Chip select is qualified by a low-level filter. A qualified falling edge resets the serial state and starts a frame. If that edge arrives while a conversion runs, the conversion is aborted. The data output has a separate output enable, so the tri-state buffer can sit at the pad.

The converter returns its result on a valid/ready stream:
- `res_ready` is high only while a conversion is pending and its result has not yet been taken.
- A result is taken in a cycle where `res_valid` and `res_ready` are both high.
- While `res_ready` is low, the converter must hold `res_valid` and `res_data`. Whatever it presents during that time is not captured.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, `sdo_oe`, `conv_start`, `conv_abort` and `res_ready` are low and `chan_addr` is 0. The result register holds 0x00, so the first frame shifts out 0x00.
- R2: The channel number is 4 bits, most significant bit first. It is sampled on rising serial clock edges during the first four clocks of the frame. Data-in bits 5 to 8 are ignored. `chan_addr` takes the new value only when the frame completes.
- R3: The shift-out value is the last captured result, most significant bit first. The first bit is present once the frame starts, and each following bit appears after a falling serial clock edge.
- R4: `sdo_oe` is high only while a frame is in progress and chip select is qualified low. It drops after the eighth falling edge, even if chip select stays low.
- R5: After the eighth clock, serial clock edges change neither `chan_addr` nor the output data. This lockout lasts until a result has been taken and `conv_busy` is low.
- R6: A chip select low level seen for fewer than `CS_QUAL` (default 3) consecutive block clock samples starts no frame. A low level held for `CS_QUAL` samples is accepted.
- R7: If a qualified chip select fall arrives during the lockout, `conv_abort` pulses for one cycle, no result is captured, and a new frame begins. That frame shifts out the previously held result.
- R8: `res_ready` is high only during the lockout, before a result has been taken. A `res_valid` presented at any other time is not captured.
- R9: Each completed eight-clock frame gives exactly one single-cycle `conv_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (converter) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial channel number in |
| sdo | output | 1 | Serial result out |
| sdo_oe | output | 1 | Output enable for the sdo pad buffer |
| chan_addr | output | 4 | Channel number latched at frame end |
| conv_start | output | 1 | One-cycle conversion start request |
| conv_abort | output | 1 | One-cycle abort of the running conversion |
| conv_busy | input | 1 | Conversion in progress |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_data | input | 8 | Result stream data |

## Verification
The hardest case to reach from the ports is the abort. It needs a fully qualified chip select fall to land inside the lockout window, after the start pulse and before the result handshake. The bench's converter model lets the test lengthen the conversion to several hundred cycles. The test can then drop and re-assert chip select well inside that window. It then checks three things: one abort pulse, a frame that still shifts out the older result, and normal operation of the following frame. Sub-threshold chip select pulses and idle-time stream traffic are driven the same way, and their effect is observed at `sdo_oe`, `conv_start` and the next frame's data.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOCK  = 2'd2
  } sp_state_t;
endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_sp_csqual.sv
module adc_sp_csqual #(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  output logic sel_q,
  output logic sel_fall
);
  localparam int             CW  = $clog2(QUAL + 1);
  localparam logic [CW-1:0]  LIM = CW'(QUAL - 1);

  logic [CW-1:0] low_cnt;
  logic          q_r, q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      q_r     <= 1'b0;
      q_d     <= 1'b0;
    end else begin
      q_d <= q_r;
      if (cs_n_s) begin
        low_cnt <= '0;
        q_r     <= 1'b0;
      end else if (!q_r) begin
        if (low_cnt == LIM) q_r <= 1'b1;
        else                low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign sel_q    = q_r;
  assign sel_fall = q_r & ~q_d;

  // R6
  cs_qual_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> ($past(!cs_n_s) && $past(!cs_n_s, 2)));
endmodule

// File: rtl/adc_sp_frame.sv
module adc_sp_frame
  import adc_sp_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_q,
  input  logic          sel_fall,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_s,
  input  logic          conv_busy,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          res_ready,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] chan_addr,
  output logic          conv_start,
  output logic          conv_abort
);
  localparam int            CW       = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ADDR_END = CW'(AW);

  sp_state_t     state_q;
  logic [CW-1:0] bitcnt;
  logic [AW-1:0] addr_sh;
  logic [DW-1:0] out_sh;
  logic [DW-1:0] res_reg;
  logic          taken;
  logic          take;

  assign res_ready = (state_q == ST_LOCK) && !taken && !sel_fall;
  assign take      = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt     <= '0;
      addr_sh    <= '0;
      out_sh     <= '0;
      res_reg    <= '0;
      chan_addr  <= '0;
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
      taken      <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      conv_abort <= 1'b0;
      if (sel_fall) begin
        if (state_q == ST_LOCK) conv_abort <= 1'b1;
        state_q <= ST_SHIFT;
        bitcnt  <= '0;
        addr_sh <= '0;
        out_sh  <= res_reg;
        taken   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_SHIFT: begin
            if (!sel_q) begin
              state_q <= ST_IDLE;
            end else begin
              if (sclk_rise && (bitcnt < ADDR_END))
                addr_sh <= {addr_sh[AW-2:0], sdi_s};
              if (sclk_fall) begin
                out_sh <= {out_sh[DW-2:0], 1'b0};
                if (bitcnt == LAST_BIT) begin
                  state_q    <= ST_LOCK;
                  chan_addr  <= addr_sh;
                  conv_start <= 1'b1;
                  taken      <= 1'b0;
                end else begin
                  bitcnt <= bitcnt + 1'b1;
                end
              end
            end
          end
          ST_LOCK: begin
            if (take) begin
              res_reg <= res_data;
              taken   <= 1'b1;
            end
            if (taken && !conv_busy) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdo    = out_sh[DW-1];
  assign sdo_oe = (state_q == ST_SHIFT) && sel_q;

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  addr_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_addr) |-> conv_start);
  // R4
  oe_off_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && sel_q && !sel_fall && sclk_fall && bitcnt == LAST_BIT) |=> !sdo_oe);
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !sel_fall) |=> ($stable(chan_addr) && $stable(out_sh)));
  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !res_ready);
  // R7
  abort_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> ($past(state_q == ST_LOCK) && state_q == ST_SHIFT));
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int SYNC_STG  = 2,
  parameter int CS_QUAL   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] chan_addr,
  output logic          conv_start,
  output logic          conv_abort,
  input  logic          conv_busy,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [DW-1:0] res_data
);
  logic [2:0] pins_s;
  logic       cs_n_s, sclk_s, sdi_s;
  logic       sclk_d;
  logic       sclk_rise, sclk_fall;
  logic       sel_q, sel_fall;

  adc_sp_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, sdi}),
    .q     (pins_s)
  );
  assign {cs_n_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  adc_sp_csqual #(.QUAL(CS_QUAL)) u_csq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .sel_q    (sel_q),
    .sel_fall (sel_fall)
  );

  adc_sp_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_q      (sel_q),
    .sel_fall   (sel_fall),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi_s      (sdi_s),
    .conv_busy  (conv_busy),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_ready  (res_ready),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .chan_addr  (chan_addr),
    .conv_start (conv_start),
    .conv_abort (conv_abort)
  );
endmodule

// File: tb/serial_adc_port_tb_top.sv
module serial_adc_port_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs_n, sclk, sdi;
  logic       sdo, sdo_oe, conv_start, conv_abort, conv_busy, res_valid, res_ready;
  logic [3:0] chan_addr;
  logic [7:0] res_data;

  serial_adc_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .chan_addr(chan_addr),
    .conv_start(conv_start), .conv_abort(conv_abort), .conv_busy(conv_busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int errors = 0;
  int checks = 0;
  int start_cnt = 0;
  int abort_cnt = 0;
  int conv_len = 40;
  bit oe_seen = 0;
  bit rdy_seen = 0;
  bit bp_en = 0;
  logic [7:0] exp_q[$];
  logic [3:0] m_addr;
  bit m_ab;
  event frame_go;

  function automatic logic [7:0] conv_of(input logic [3:0] a);
    return {a, ~a} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (conv_start) start_cnt++;
    if (conv_abort) abort_cnt++;
    if (sdo_oe) oe_seen = 1;
    if (res_ready) rdy_seen = 1;
  end

  // converter model: stimulus side of the result stream
  initial begin
    conv_busy = 0; res_valid = 0; res_data = 8'h00;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        m_addr = chan_addr;
        m_ab = 0;
        conv_busy = 1;
        res_valid = 0;
        for (int i = 0; i < conv_len; i++) begin
          @(negedge clk);
          if (conv_abort) begin m_ab = 1; break; end
        end
        if (!m_ab) begin
          res_data = conv_of(m_addr);
          res_valid = 1;
          while (!res_ready) @(negedge clk);
          @(negedge clk);
          res_valid = 0;
        end
        conv_busy = 0;
      end else begin
        res_valid = bp_en;
        if (bp_en) res_data = 8'hEE;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      logic [7:0] got;
      logic [7:0] exp;
      bit oe_ok;
      @(frame_go);
      got = '0;
      oe_ok = 1;
      for (int i = 0; i < 8; i++) begin
        @(posedge sclk);
        got = {got[6:0], sdo};
        if (!sdo_oe) oe_ok = 0;
      end
      exp = exp_q.pop_front();
      chk(got == exp, "R3 shifted result", got, exp);
      chk(oe_ok, "R4 oe during frame", oe_ok, 1);
    end
  end

  task automatic sclk_pulse(input logic b);
    sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1;
    repeat (6) @(negedge clk);
    sclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_frame(input logic [3:0] addr, input logic [7:0] exp, input logic [3:0] tail);
    int s0;
    s0 = start_cnt;
    exp_q.push_back(exp);
    cs_n = 0;
    repeat (10) @(negedge clk);
    ->frame_go;
    for (int i = 0; i < 8; i++)
      sclk_pulse(i < 4 ? addr[3-i] : tail[7-i]);
    repeat (6) @(negedge clk);
    chk(sdo_oe == 0, "R4 oe off after eighth clock", sdo_oe, 0);
    chk(chan_addr == addr, "R2 latched channel", chan_addr, addr);
    chk(start_cnt == s0 + 1, "R9 one start per frame", start_cnt - s0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s;
    rst_n = 0; cs_n = 1; sclk = 0; sdi = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sdo_oe == 0 && conv_start == 0 && conv_abort == 0, "R1 reset outputs", sdo_oe, 0);
    chk(chan_addr == 0, "R1 reset channel", chan_addr, 0);
    chk(res_ready == 0, "R1 reset ready", res_ready, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1: first frame reads 0x00; R2 tail bits ignored
    do_frame(4'h5, 8'h00, 4'hF);
    cs_n = 1;
    repeat (80) @(negedge clk);

    // R5 lockout: keep CS low and clock during conversion
    do_frame(4'hA, conv_of(4'h5), 4'h0);
    oe_seen = 0;
    s = start_cnt;
    for (int i = 0; i < 4; i++) begin
      sdi = 1; sclk = 1; repeat (2) @(negedge clk);
      sclk = 0; repeat (2) @(negedge clk);
    end
    chk(chan_addr == 4'hA, "R5 channel held in lockout", chan_addr, 4'hA);
    chk(start_cnt == s && oe_seen == 0, "R5 no activity in lockout", start_cnt - s, 0);
    cs_n = 1;
    repeat (80) @(negedge clk);

    do_frame(4'h0, conv_of(4'hA), 4'h9);
    cs_n = 1;
    repeat (80) @(negedge clk);

    // R8: stream traffic while idle is not taken
    rdy_seen = 0;
    bp_en = 1;
    repeat (20) @(negedge clk);
    bp_en = 0;
    chk(rdy_seen == 0, "R8 ready low while idle", rdy_seen, 0);
    do_frame(4'hF, conv_of(4'h0), 4'h3);
    cs_n = 1;
    repeat (80) @(negedge clk);

    // R6: short chip select pulses
    oe_seen = 0;
    s = start_cnt;
    cs_n = 0; @(negedge clk); cs_n = 1;
    repeat (8) @(negedge clk);
    cs_n = 0; repeat (2) @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) sclk_pulse(1'b1);
    repeat (10) @(negedge clk);
    chk(oe_seen == 0, "R6 glitch gives no output enable", oe_seen, 0);
    chk(start_cnt == s, "R6 glitch gives no start", start_cnt - s, 0);
    do_frame(4'h9, conv_of(4'hF), 4'h6);
    cs_n = 1;
    repeat (80) @(negedge clk);

    // R7: abort with a long conversion
    conv_len = 400;
    do_frame(4'h3, conv_of(4'h9), 4'h0);
    cs_n = 1;
    repeat (20) @(negedge clk);
    s = abort_cnt;
    do_frame(4'h6, conv_of(4'h9), 4'hC);
    conv_len = 40;
    chk(abort_cnt == s + 1, "R7 one abort pulse", abort_cnt - s, 1);
    cs_n = 1;
    repeat (80) @(negedge clk);
    do_frame(4'h2, conv_of(4'h6), 4'h0);
    cs_n = 1;
    repeat (80) @(negedge clk);
    chk(abort_cnt == s + 1, "R7 no further aborts", abort_cnt - s, 1);
    chk(exp_q.size() == 0, "R3 all frames compared", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule